// File: doc/BRIEF.md
# Prefixed Rotate, Shift and Bit Unit

This unit executes the second byte of a bit/rotate prefixed opcode on one 8-bit operand. From the opcode it picks one of eight rotate or shift kinds, a single-bit test, a single-bit clear or a single-bit set. It returns the new operand value, a write-back enable, the updated flag byte, and the 3-bit operand-select field that the register file or memory path uses to locate the operand and its destination.

A separate mode input turns the unit into the short accumulator-only rotate path. In that mode only the carry and the two arithmetic-status bits change, and the sign, zero and parity bits pass through untouched. Fetching the operand and handling displacements are left to the surrounding datapath. All outputs are registered, so results appear one clock after the inputs are presented.

Flag byte layout (bit: meaning): 7 sign, 6 zero, 5 result-copy Y, 4 half carry, 3 result-copy X, 2 parity/overflow, 1 subtract, 0 carry.

Top module: `bit_rot_unit`

## Requirements
- R1: While rst_ni is low, result_o, wr_en_o, flags_o and sel_o are all zero. Every output reflects the inputs sampled at the previous rising clock edge.
- R2: With acc_mode_i low and op_i[7:6]=00, op_i[5:3] selects the operation. 0 rotates left circular, 1 rotates right circular, 2 rotates left through carry, 3 rotates right through carry, 4 shifts left with 0 into bit 0, 5 shifts right keeping bit 7, 6 shifts left with 1 into bit 0, and 7 shifts right with 0 into bit 7. Carry (flag bit 0) takes the bit shifted out.
- R3: For those rotates and shifts, sign (bit 7) equals result bit 7. Zero (bit 6) is set for a zero result. Parity (bit 2) is set for an even count of ones. Half carry (bit 4) and subtract (bit 1) are cleared.
- R4: With op_i[7:6]=01, the unit tests bit op_i[5:3] of the operand. Zero and parity are set when that bit is 0, half carry is set, subtract is cleared, and sign and carry keep their incoming values.
- R5: With op_i[7:6]=10 the selected bit is cleared, and with 11 it is set. The bit index is op_i[5:3], the other bits are unchanged, and flags_o equals flags_i.
- R6: With acc_mode_i high, op_i[4:3] selects one of rotate kinds 0..3 from R2, and op_i[7:5] is ignored. Carry takes the bit shifted out, half carry and subtract are cleared, and sign, zero and parity keep their incoming values.
- R7: sel_o equals op_i[2:0] in every mode. The value 6 denotes the memory operand.
- R8: Flag bits 5 and 3 pass through from flags_i unchanged for every operation.
- R9: wr_en_o is high for every rotate, shift, set and clear, including accumulator mode. It is low for bit test, and in that case result_o equals the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 8 | Second opcode byte |
| acc_mode_i | input | 1 | Selects the short accumulator rotate path |
| data_i | input | 8 | Operand value |
| flags_i | input | 8 | Incoming flag byte |
| result_o | output | 8 | New operand value |
| wr_en_o | output | 1 | Write result back to the operand location |
| flags_o | output | 8 | Updated flag byte |
| sel_o | output | 3 | Operand-select field from the opcode |

## Verification
The opcode decode and the accumulator mode can both claim the same cycle when acc_mode_i is high and op_i also carries a bit-test, set or clear encoding. The bench drives accumulator mode with opcodes from every upper-bit group, both directed (for example 0xC7 and 0x4F) and random. It then judges that only op_i[4:3] shaped the result, that write-back stays high, and that sign, zero and parity come straight from flags_i.

// File: rtl/bit_rot_pkg.sv
package bit_rot_pkg;
  localparam int FL_C  = 0;
  localparam int FL_N  = 1;
  localparam int FL_PV = 2;
  localparam int FL_X  = 3;
  localparam int FL_H  = 4;
  localparam int FL_Y  = 5;
  localparam int FL_Z  = 6;
  localparam int FL_S  = 7;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'b00,
    GRP_TEST  = 2'b01,
    GRP_CLR   = 2'b10,
    GRP_SET   = 2'b11
  } grp_e;

  typedef enum logic [2:0] {
    K_ROL_C = 3'd0,
    K_ROR_C = 3'd1,
    K_ROL_T = 3'd2,
    K_ROR_T = 3'd3,
    K_SHL_0 = 3'd4,
    K_SHR_A = 3'd5,
    K_SHL_1 = 3'd6,
    K_SHR_0 = 3'd7
  } kind_e;
endpackage

// File: rtl/shift_core.sv
module shift_core
  import bit_rot_pkg::*;
#(
  parameter int W = 8
) (
  input  kind_e          kind_i,
  input  logic [W-1:0]   data_i,
  input  logic           carry_i,
  output logic [W-1:0]   res_o,
  output logic           carry_o
);
  localparam int MSB = W - 1;

  always_comb begin
    unique case (kind_i)
      K_ROL_C: res_o = {data_i[MSB-1:0], data_i[MSB]};
      K_ROR_C: res_o = {data_i[0], data_i[MSB:1]};
      K_ROL_T: res_o = {data_i[MSB-1:0], carry_i};
      K_ROR_T: res_o = {carry_i, data_i[MSB:1]};
      K_SHL_0: res_o = {data_i[MSB-1:0], 1'b0};
      K_SHR_A: res_o = {data_i[MSB], data_i[MSB:1]};
      K_SHL_1: res_o = {data_i[MSB-1:0], 1'b1};
      default: res_o = {1'b0, data_i[MSB:1]};
    endcase
    // odd kinds move right, so bit 0 falls out
    carry_o = kind_i[0] ? data_i[0] : data_i[MSB];
  end
endmodule

// File: rtl/bit_core.sv
module bit_core #(
  parameter int W = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic             set_i,
  input  logic [W-1:0]     data_i,
  output logic [W-1:0]     res_o,
  output logic             bit_o
);
  logic [W-1:0] mask;

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign mask[i] = (idx_i == IDX_W'(i));
  end

  assign res_o = set_i ? (data_i | mask) : (data_i & ~mask);
  assign bit_o = |(data_i & mask);
endmodule

// File: rtl/bit_rot_unit.sv
module bit_rot_unit
  import bit_rot_pkg::*;
#(
  parameter int W = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [7:0]   op_i,
  input  logic         acc_mode_i,
  input  logic [W-1:0] data_i,
  input  logic [7:0]   flags_i,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic [7:0]   flags_o,
  output logic [2:0]   sel_o
);
  grp_e         grp;
  kind_e        kind;
  logic [W-1:0] sh_res, bc_res, res_d;
  logic         sh_carry, bc_bit, we_d;
  logic [7:0]   fl_d;

  assign grp  = grp_e'(op_i[7:6]);
  assign kind = acc_mode_i ? kind_e'({1'b0, op_i[4:3]}) : kind_e'(op_i[5:3]);

  shift_core #(.W(W)) u_shift (
    .kind_i  (kind),
    .data_i  (data_i),
    .carry_i (flags_i[FL_C]),
    .res_o   (sh_res),
    .carry_o (sh_carry)
  );

  bit_core #(.W(W)) u_bit (
    .idx_i  (op_i[3 +: IDX_W]),
    .set_i  (op_i[6]),
    .data_i (data_i),
    .res_o  (bc_res),
    .bit_o  (bc_bit)
  );

  always_comb begin
    res_d = data_i;
    we_d  = 1'b1;
    fl_d  = flags_i;
    if (acc_mode_i) begin
      res_d       = sh_res;
      fl_d[FL_C]  = sh_carry;
      fl_d[FL_H]  = 1'b0;
      fl_d[FL_N]  = 1'b0;
    end else begin
      unique case (grp)
        GRP_SHIFT: begin
          res_d       = sh_res;
          fl_d[FL_S]  = sh_res[W-1];
          fl_d[FL_Z]  = (sh_res == '0);
          fl_d[FL_PV] = ~^sh_res;
          fl_d[FL_H]  = 1'b0;
          fl_d[FL_N]  = 1'b0;
          fl_d[FL_C]  = sh_carry;
        end
        GRP_TEST: begin
          we_d        = 1'b0;
          fl_d[FL_Z]  = ~bc_bit;
          fl_d[FL_PV] = ~bc_bit;
          fl_d[FL_H]  = 1'b1;
          fl_d[FL_N]  = 1'b0;
        end
        default: res_d = bc_res;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      wr_en_o  <= 1'b0;
      flags_o  <= '0;
      sel_o    <= '0;
    end else begin
      result_o <= res_d;
      wr_en_o  <= we_d;
      flags_o  <= fl_d;
      sel_o    <= op_i[2:0];
    end
  end
endmodule

// File: rtl/bit_rot_unit_chk.sv
module bit_rot_unit_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [7:0]   op_i,
  input logic         acc_mode_i,
  input logic [W-1:0] data_i,
  input logic [7:0]   flags_i,
  input logic [W-1:0] result_o,
  input logic         wr_en_o,
  input logic [7:0]   flags_o,
  input logic [2:0]   sel_o
);
  logic armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  always_comb begin
    if (!rst_ni) begin
      a_reset_zero_r1: assert (result_o == '0 && !wr_en_o && flags_o == '0 && sel_o == '0);
    end
  end

  p_shift_flags_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(!acc_mode_i && op_i[7:6] == 2'b00)
      |-> !flags_o[4] && !flags_o[1] && flags_o[2] == ~^result_o
          && flags_o[7] == result_o[W-1]);

  p_test_no_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(!acc_mode_i && op_i[7:6] == 2'b01)
      |-> !wr_en_o && flags_o[4] && !flags_o[1] && result_o == $past(data_i));

  p_setclr_flags_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(!acc_mode_i && op_i[7]) |-> flags_o == $past(flags_i) && wr_en_o);

  p_acc_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(acc_mode_i)
      |-> flags_o[7:6] == $past(flags_i[7:6]) && flags_o[2] == $past(flags_i[2])
          && !flags_o[4] && !flags_o[1] && wr_en_o);

  p_sel_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> sel_o == $past(op_i[2:0]));

  p_xy_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> flags_o[5] == $past(flags_i[5]) && flags_o[3] == $past(flags_i[3]));
endmodule

bind bit_rot_unit bit_rot_unit_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_i       (op_i),
  .acc_mode_i (acc_mode_i),
  .data_i     (data_i),
  .flags_i    (flags_i),
  .result_o   (result_o),
  .wr_en_o    (wr_en_o),
  .flags_o    (flags_o),
  .sel_o      (sel_o)
);

// File: tb/bit_rot_unit_tb_top.sv
module bit_rot_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] op = '0;
  logic       acc = 1'b0;
  logic [7:0] data = '0;
  logic [7:0] fl = '0;
  logic [7:0] result;
  logic       wr_en;
  logic [7:0] flags;
  logic [2:0] sel;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bit_rot_unit dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .op_i       (op),
    .acc_mode_i (acc),
    .data_i     (data),
    .flags_i    (fl),
    .result_o   (result),
    .wr_en_o    (wr_en),
    .flags_o    (flags),
    .sel_o      (sel)
  );

  // packed {result, we, flags, sel}
  function automatic logic [19:0] model(input logic [7:0] o, input logic a,
                                        input logic [7:0] d, input logic [7:0] f);
    logic [7:0] r = d;
    logic [7:0] nf = f;
    logic       w = 1'b1;
    logic       c = f[0];
    logic [2:0] k = a ? {1'b0, o[4:3]} : o[5:3];
    logic       z;
    if (a || o[7:6] == 2'b00) begin
      case (k)
        3'd0: begin r = {d[6:0], d[7]}; c = d[7]; end
        3'd1: begin r = {d[0], d[7:1]}; c = d[0]; end
        3'd2: begin r = {d[6:0], f[0]}; c = d[7]; end
        3'd3: begin r = {f[0], d[7:1]}; c = d[0]; end
        3'd4: begin r = {d[6:0], 1'b0}; c = d[7]; end
        3'd5: begin r = {d[7], d[7:1]}; c = d[0]; end
        3'd6: begin r = {d[6:0], 1'b1}; c = d[7]; end
        default: begin r = {1'b0, d[7:1]}; c = d[0]; end
      endcase
      nf[0] = c; nf[4] = 1'b0; nf[1] = 1'b0;
      if (!a) begin
        nf[7] = r[7];
        nf[6] = (r == 8'h00);
        nf[2] = ~^r;
      end
    end else if (o[7:6] == 2'b01) begin
      w = 1'b0;
      z = ~d[o[5:3]];
      nf[6] = z; nf[2] = z; nf[4] = 1'b1; nf[1] = 1'b0;
    end else if (o[7:6] == 2'b10) begin
      r[o[5:3]] = 1'b0;
    end else begin
      r[o[5:3]] = 1'b1;
    end
    return {r, w, nf, o[2:0]};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%02h expected=%02h (op=%02h acc=%0b d=%02h f=%02h)",
               req, what, act, exp, op, acc, data, fl);
    end
  endtask

  task automatic apply(input logic [7:0] o, input logic a,
                       input logic [7:0] d, input logic [7:0] f);
    logic [19:0] e;
    string rq_res, rq_fl;
    op = o; acc = a; data = d; fl = f;
    e = model(o, a, d, f);
    if (a)                     begin rq_res = "R6"; rq_fl = "R6"; end
    else if (o[7:6] == 2'b00)  begin rq_res = "R2"; rq_fl = "R3"; end
    else if (o[7:6] == 2'b01)  begin rq_res = "R9"; rq_fl = "R4"; end
    else                       begin rq_res = "R5"; rq_fl = "R5"; end
    @(negedge clk);
    check(rq_res, "result", result, e[19:12]);
    check("R9", "wr_en", {7'd0, wr_en}, {7'd0, e[11]});
    check(rq_fl, "flags", flags, e[10:3]);
    check("R8", "flags_xy", flags & 8'h28, f & 8'h28);
    check("R7", "sel", {5'd0, sel}, {5'd0, e[2:0]});
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_c0de);
    op = 8'h3f; data = 8'hff; fl = 8'hff; acc = 1'b1;
    #(CLK_PERIOD * 2 + 2);
    // R1: outputs held at zero during reset
    check("R1", "reset result", result, 8'h00);
    check("R1", "reset flags", flags, 8'h00);
    check("R1", "reset wr_en/sel", {4'd0, wr_en, sel}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // directed corners
    apply(8'h30, 1'b0, 8'h80, 8'h00); // R2 shift-in-one: 01, carry 1
    apply(8'h37, 1'b0, 8'h00, 8'h28); // R2 shift-in-one of zero: 01
    apply(8'h28, 1'b0, 8'h81, 8'h00); // R2 arith right keeps bit 7
    apply(8'h38, 1'b0, 8'h01, 8'h00); // R3 logical right to zero: Z=1, C=1
    apply(8'h16, 1'b0, 8'h80, 8'h01); // R2 rotate left through carry, memory sel 6
    apply(8'h1e, 1'b0, 8'h01, 8'h00); // R3 rotate right through carry -> 0
    apply(8'h7e, 1'b0, 8'h00, 8'h81); // R4 test bit 7 of zero: Z=1
    apply(8'h46, 1'b0, 8'h01, 8'hff); // R4 test bit 0 set: Z=0
    apply(8'hbf, 1'b0, 8'hff, 8'h55); // R5 clear bit 7
    apply(8'hc0, 1'b0, 8'h00, 8'haa); // R5 set bit 0
    apply(8'hc7, 1'b1, 8'h80, 8'hc4); // R6 acc mode overrides set encoding
    apply(8'h4f, 1'b1, 8'h01, 8'h00); // R6 acc mode overrides test encoding
    apply(8'h17, 1'b1, 8'h00, 8'hff); // R6 rotate through carry, S/Z/PV kept

    for (int i = 0; i < 600; i++) begin
      apply(8'($urandom), ($urandom % 4) == 0, 8'($urandom), 8'($urandom));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule